// File: doc/BRIEF.md
# Battery Check Scheduler

This block decides when the backup battery is measured and keeps the outcome as a status flag. When the main supply becomes good, it runs a check at once. It then runs a further check each time a set number of slow timebase ticks has passed, which by default is one day of one-second ticks. No check runs while the part is on battery backup.

Each check raises a sense-enable output for a fixed number of cycles so that the external comparator can settle. The comparator is read on the last of those cycles. The result sets or clears a battery-low bit in a flags byte. A second bit tells whether a low result came from the power-up check or from a periodic one. Software can use it to tell possibly corrupted memory contents apart from an end-of-life warning. Software reads the flags byte with a one-cycle read strobe.

Top module: `batt_check_top`

## Requirements
- R1: When `supply_ok` rises, including at the first clock after reset if it is already high, `sense_en` goes high on the next clock edge.
- R2: During a check `sense_en` stays high for exactly SETTLE_CYCLES cycles. The stored result is the value of `batt_below` on the last of those cycles (1 = battery below threshold).
- R3: While `supply_ok` stays high, a periodic check starts on the clock after the TICKS_PER_INTERVAL-th `tick_1s` pulse, counted since the last rise of `supply_ok` or since the last periodic check. The next clock after that pulse starts the check, and no earlier tick does.
- R4: While `supply_ok` is low, no check starts, ticks are not counted, and the battery-low and origin bits are held at 0.
- R5: Bit 4 of the flags byte holds the result of the latest completed check, with 1 meaning battery low.
- R6: Bit 6 of the flags byte is 1 when bit 4 was set by a power-up check. It is 0 when bit 4 was set by a periodic check or when bit 4 is 0.
- R7: `flags_q` loads the current status on the clock edge where `flags_rd` is high and holds its value otherwise. All bits other than 4 and 6 read as 0.
- R8: If `supply_ok` falls during a check, `sense_en` is low on the next cycle and no result is stored.
- R9: After reset, `flags_q` is 0 and `sense_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Main supply good, synchronous to clk |
| tick_1s | input | 1 | One-cycle timebase pulse |
| batt_below | input | 1 | Comparator output, 1 = battery below threshold |
| flags_rd | input | 1 | Read strobe for the flags byte |
| sense_en | output | 1 | Comparator enable during a check |
| flags_q | output | 8 | Registered flags byte |

## Verification
The assertions assume that `supply_ok` and `tick_1s` are already synchronous to `clk` and that each tick is a single-cycle pulse. The bench drives every input at the falling edge, so each value is stable across a full rising edge. Ticks are always issued as a one-cycle high followed by a low cycle. The interval is shortened through its parameter, so periodic checks, interval restarts and checks aborted by a supply drop all fit in a short run.

// File: rtl/batt_pkg.sv
package batt_pkg;
  typedef enum logic {
    SEQ_IDLE   = 1'b0,
    SEQ_SETTLE = 1'b1
  } seq_state_t;

  typedef struct packed {
    logic low;
    logic from_pwr;
  } check_result_t;
endpackage

// File: rtl/batt_interval_timer.sv
module batt_interval_timer #(
  parameter int TICKS_PER_INTERVAL = 86400
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic pwr_rise,
  input  logic tick_1s,
  output logic periodic_req
);
  localparam int CNT_W = (TICKS_PER_INTERVAL > 1) ? $clog2(TICKS_PER_INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_INTERVAL - 1);

  logic [CNT_W-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok || pwr_rise) begin
      tick_cnt     <= '0;
      periodic_req <= 1'b0;
    end else begin
      periodic_req <= 1'b0;
      if (tick_1s) begin
        if (tick_cnt == LAST) begin
          tick_cnt     <= '0;
          periodic_req <= 1'b1;
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end

  AST_REQ_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
    periodic_req |-> $past(tick_1s) && $past(supply_ok)); // R3
endmodule

// File: rtl/batt_check_seq.sv
module batt_check_seq
  import batt_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          supply_ok,
  input  logic          start_pwr,
  input  logic          start_per,
  input  logic          batt_below,
  output logic          sense_en,
  output logic          done,
  output check_result_t result
);
  localparam int SET_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [SET_W-1:0] LAST = SET_W'(SETTLE_CYCLES - 1);

  seq_state_t       state;
  logic [SET_W-1:0] settle_cnt;
  logic             origin_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      settle_cnt <= '0;
      origin_r   <= 1'b0;
      sense_en   <= 1'b0;
      done       <= 1'b0;
      result     <= '0;
    end else begin
      done <= 1'b0;
      if (!supply_ok) begin
        state    <= SEQ_IDLE;
        sense_en <= 1'b0;
      end else begin
        case (state)
          SEQ_IDLE: begin
            if (start_pwr || start_per) begin
              state      <= SEQ_SETTLE;
              sense_en   <= 1'b1;
              settle_cnt <= '0;
              origin_r   <= start_pwr;
            end
          end
          SEQ_SETTLE: begin
            if (settle_cnt == LAST) begin
              result.low      <= batt_below;
              result.from_pwr <= origin_r;
              done            <= 1'b1;
              sense_en        <= 1'b0;
              state           <= SEQ_IDLE;
            end else begin
              settle_cnt <= settle_cnt + 1'b1;
            end
          end
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end

  AST_EN_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    sense_en |-> $past(supply_ok)); // R4
  AST_DONE_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(sense_en) && !sense_en); // R2
  AST_PWR_STARTS: assert property (@(posedge clk) disable iff (rst)
    start_pwr |=> sense_en); // R1
endmodule

// File: rtl/batt_flag_reg.sv
module batt_flag_reg
  import batt_pkg::*;
#(
  parameter int FLAG_W     = 8,
  parameter int LOW_POS    = 4,
  parameter int ORIGIN_POS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok,
  input  logic              done,
  input  check_result_t     result,
  input  logic              flags_rd,
  output logic [FLAG_W-1:0] flags_q
);
  logic              low_r;
  logic              origin_r;
  logic [FLAG_W-1:0] status_vec;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok) begin
      low_r    <= 1'b0;
      origin_r <= 1'b0;
    end else if (done) begin
      low_r    <= result.low;
      origin_r <= result.low & result.from_pwr;
    end
  end

  always_comb begin
    for (int i = 0; i < FLAG_W; i++) begin
      status_vec[i] = (i == LOW_POS) ? low_r : ((i == ORIGIN_POS) ? origin_r : 1'b0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else if (flags_rd) flags_q <= status_vec;
  end

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !low_r && !origin_r); // R4
  AST_ORIGIN_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    origin_r |-> low_r); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flags_rd |=> $stable(flags_q)); // R7
endmodule

// File: rtl/batt_check_top.sv
module batt_check_top
  import batt_pkg::*;
#(
  parameter int TICKS_PER_INTERVAL = 86400,
  parameter int SETTLE_CYCLES      = 8,
  parameter int FLAG_W             = 8,
  parameter int LOW_POS            = 4,
  parameter int ORIGIN_POS         = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok,
  input  logic              tick_1s,
  input  logic              batt_below,
  input  logic              flags_rd,
  output logic              sense_en,
  output logic [FLAG_W-1:0] flags_q
);
  logic          supply_q;
  logic          pwr_rise;
  logic          periodic_req;
  logic          check_done;
  check_result_t check_res;

  always_ff @(posedge clk) begin
    if (rst) supply_q <= 1'b0;
    else     supply_q <= supply_ok;
  end

  assign pwr_rise = supply_ok & ~supply_q;

  batt_interval_timer #(
    .TICKS_PER_INTERVAL(TICKS_PER_INTERVAL)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .supply_ok   (supply_ok),
    .pwr_rise    (pwr_rise),
    .tick_1s     (tick_1s),
    .periodic_req(periodic_req)
  );

  batt_check_seq #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .start_pwr (pwr_rise),
    .start_per (periodic_req),
    .batt_below(batt_below),
    .sense_en  (sense_en),
    .done      (check_done),
    .result    (check_res)
  );

  batt_flag_reg #(
    .FLAG_W    (FLAG_W),
    .LOW_POS   (LOW_POS),
    .ORIGIN_POS(ORIGIN_POS)
  ) u_flags (
    .clk      (clk),
    .rst      (rst),
    .supply_ok(supply_ok),
    .done     (check_done),
    .result   (check_res),
    .flags_rd (flags_rd),
    .flags_q  (flags_q)
  );

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pwr_rise |=> !pwr_rise); // R1
endmodule

// File: tb/tb_batt_check_top.sv
module tb_batt_check_top;
  localparam int TICKS  = 8;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic tick_1s = 1'b0;
  logic batt_below = 1'b0;
  logic flags_rd = 1'b0;
  logic sense_en;
  logic [7:0] flags_q;

  int checks = 0;
  int fails = 0;
  int rises = 0;
  int cyc = 0;
  logic en_prev = 1'b0;
  logic [7:0] rd_val;

  always #2.5 clk = ~clk;

  batt_check_top #(
    .TICKS_PER_INTERVAL(TICKS),
    .SETTLE_CYCLES     (SETTLE)
  ) dut (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .tick_1s   (tick_1s),
    .batt_below(batt_below),
    .flags_rd  (flags_rd),
    .sense_en  (sense_en),
    .flags_q   (flags_q)
  );

  always @(posedge clk) begin
    en_prev <= sense_en;
    if (sense_en && !en_prev) rises <= rises + 1;
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic read_flags(output logic [7:0] v);
    @(negedge clk) flags_rd = 1'b1;
    @(negedge clk) flags_rd = 1'b0;
    v = flags_q;
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1s = 1'b1;
      @(negedge clk) tick_1s = 1'b0;
    end
  endtask

  task automatic power_cycle();
    @(negedge clk) supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
  endtask

  // Called right after the trigger; measures the check and reads the flags.
  task automatic run_check(input logic early, input logic last, input string tag,
                           output logic [7:0] v);
    int w;
    int hi;
    batt_below = early;
    w = 0;
    @(negedge clk);
    while (!sense_en && w < 20) begin
      @(negedge clk);
      w++;
    end
    chk({tag, " R1/R3 start delay"}, w, 0);
    hi = 0;
    while (sense_en && hi < 50) begin
      hi++;
      if (hi == SETTLE) batt_below = last;
      @(negedge clk);
    end
    chk({tag, " R2 enable width"}, hi, SETTLE);
    read_flags(v);
  endtask

  // {early, last, periodic, expected flags}
  localparam logic [10:0] VEC [7] = '{
    {1'b1, 1'b1, 1'b0, 8'h50},
    {1'b1, 1'b1, 1'b1, 8'h10},
    {1'b0, 1'b0, 1'b1, 8'h00},
    {1'b1, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b1, 1'b1, 8'h10},
    {1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'h50}
  };

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    chk("R9 flags after reset", flags_q, 0);
    chk("R9 sense_en after reset", sense_en, 0);
    @(negedge clk) rst = 1'b0;
    repeat (2) @(negedge clk);

    // R4: no checks or counting while supply is low
    r0 = rises;
    give_ticks(3 * TICKS);
    repeat (3) @(negedge clk);
    chk("R4 no check while off", rises, r0);
    read_flags(rd_val);
    chk("R4 flags while off", rd_val, 0);

    // First power-up via the vector table
    for (int k = 0; k < 7; k++) begin
      if (!VEC[k][8]) begin
        power_cycle();
      end else begin
        give_ticks(TICKS);
      end
      run_check(VEC[k][10], VEC[k][9], $sformatf("vec%0d", k), rd_val);
      chk($sformatf("vec%0d R5/R6 flags", k), rd_val, VEC[k][7:0]);
    end

    // R7: flags_q holds without a read even after the status clears
    @(negedge clk) supply_ok = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 hold without read", flags_q, 8'h50);
    read_flags(rd_val);
    chk("R4 cleared when off", rd_val, 0);

    // R3: exact interval and restart on power-up
    supply_ok = 1'b1;
    run_check(1'b0, 1'b0, "r3_pwr", rd_val);
    give_ticks(TICKS / 2);
    power_cycle();
    run_check(1'b0, 1'b0, "r3_restart", rd_val);
    r0 = rises;
    give_ticks(TICKS - 1);
    repeat (3) @(negedge clk);
    chk("R3 no early check", rises, r0);
    give_ticks(1);
    run_check(1'b1, 1'b1, "r3_exact", rd_val);
    chk("R3 periodic flags", rd_val, 8'h10);

    // R8: supply drop mid-check aborts
    power_cycle();
    batt_below = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 enable during check", sense_en, 1);
    supply_ok = 1'b0;
    @(negedge clk);
    chk("R8 enable drops", sense_en, 0);
    repeat (SETTLE + 2) @(negedge clk);
    chk("R8 no late enable", sense_en, 0);
    read_flags(rd_val);
    chk("R8 no result stored", rd_val, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule